// File: doc/BRIEF.md
# DRAM Data-Output Buffer Control

This block is a clock-sampled behavioural model of the output side of an asynchronous DRAM. A controller testbench presents the row strobe, column strobe, write enable and output enable, all active low, once per clock. It also presents the word the cell array would return. The model then decides whether the data pins float, drive newly read data or keep the word already latched. Controller verification uses it to catch bus contention and stale-data assumptions without modelling nanosecond timing.

Each cycle is classified as a read, an early write, a late write, a read-modify-write or an indeterminate sequence. That class sets when the output may be driven again and when it must turn off. A parameter picks fast-page behaviour (`EDO_MODE = 0`) or extended-data-out behaviour (`EDO_MODE = 1`). The two differ in which strobe rise ends the data window. Every output is registered, so a change seen on the inputs at one clock edge shows at the outputs just after that same edge.

Top module: `dram_dq_ctrl`

## Requirements
- R1: After reset `dq_drv` and `dq_indet` are 0 and `dq_q` is all zeros.
- R2: When the column strobe is first sampled low while the row strobe is low and write enable is high, `cell_data` is latched into `dq_q` at that edge. `dq_drv` is 1 after that edge if output enable is sampled low.
- R3: With `EDO_MODE = 0`, `dq_drv` is 0 after any edge at which the row strobe or the column strobe is sampled high.
- R4: With `EDO_MODE = 1`, read data stays driven until both strobes are sampled high together. A column strobe raised and lowered again while the row strobe stays low replaces `dq_q` with the new `cell_data`.
- R5: If the row strobe falls while the column strobe is already low, no new data is latched and `dq_q` keeps the previous word. In EDO mode that word stays driven.
- R6: A cycle whose write enable is low at the column strobe fall is an early write. `dq_drv` stays 0 for the rest of the cycle whatever output enable does, and `dq_q` is unchanged.
- R7: If write enable falls during a read while output enable is high and the read data was never driven, the cycle is a late write. The output is open while output enable is high. If output enable returns low while the column strobe is still low, the previously latched word is driven again and the current `cell_data` is ignored.
- R8: In a late write, once the column strobe rises before output enable returns low, `dq_drv` stays 0 in both modes.
- R9: If read data was driven, output enable then rose, and write enable then fell, the cycle is a read-modify-write. Output enable low again drives the read word. In EDO mode that word also survives a later column strobe rise.
- R10: A write enable fall during a read while output enable is low sets `dq_indet` to 1. It stays 1 until a new read latch or until a row strobe fall with the column strobe high.
- R11: `dq_drv` is 1 only while output enable is sampled low. Raising output enable during a read turns the output off, and lowering it again turns the output back on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| cell_data | input | DATA_W | Word returned by the cell array |
| dq_q | output | DATA_W | Latched output word |
| dq_drv | output | 1 | 1 when the data pins are driven, 0 when they float |
| dq_indet | output | 1 | 1 when the output data of this cycle is indeterminate |

## Verification
A wrong cycle class or a stale valid bit shows up on `dq_drv` just after the first edge where output enable is sampled low. The model either drives during a write that should float, or floats on a read-modify-write that should drive. A wrong latch decision shows on `dq_q` right after the column strobe fall, or after a row strobe fall with the column strobe held low. For this reason the cell data is changed at those edges. A mode error shows at the single edge where only one strobe has risen, so both modes run side by side on the same stimulus.

// File: rtl/dqb_pkg.sv
package dqb_pkg;
   localparam int unsigned NSTB  = 4;
   localparam int unsigned NEDGE = 3;
   localparam int unsigned I_RAS = 0;
   localparam int unsigned I_CAS = 1;
   localparam int unsigned I_WE  = 2;
   localparam int unsigned I_OE  = 3;

   typedef enum logic [2:0] {
      CYC_IDLE     = 3'd0,
      CYC_READ     = 3'd1,
      CYC_EARLY_WR = 3'd2,
      CYC_LATE_WR  = 3'd3,
      CYC_RMW      = 3'd4,
      CYC_INDET    = 3'd5
   } cyc_e;
endpackage

// File: rtl/dqb_sampler.sv
module dqb_sampler #(
   parameter int unsigned N_STB  = 4,
   parameter int unsigned N_EDGE = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_STB-1:0]  stb_n,
   output logic [N_STB-1:0]  lvl_q,
   output logic [N_EDGE-1:0] fall
);
   if (N_EDGE > N_STB) begin : g_bad_edges
      $error("dqb_sampler: N_EDGE must not exceed N_STB");
   end

   for (genvar g = 0; g < N_STB; g++) begin : g_lvl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl_q[g] <= 1'b1;
         else        lvl_q[g] <= stb_n[g];
      end
   end

   for (genvar e = 0; e < N_EDGE; e++) begin : g_fall
      assign fall[e] = lvl_q[e] & ~stb_n[e];
   end
endmodule

// File: rtl/dqb_classifier.sv
module dqb_classifier
   import dqb_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NSTB-1:0]  stb_n,
   input  logic [NEDGE-1:0] fall,
   output cyc_e             cls_q,
   output logic             latch,
   output logic             wr_kill
);
   logic row_open;
   logic shown_q, shown_d;
   cyc_e cls_d;

   assign row_open = ~stb_n[I_RAS];
   assign latch    = fall[I_CAS] & row_open &  stb_n[I_WE];
   assign wr_kill  = fall[I_CAS] & row_open & ~stb_n[I_WE];

   always_comb begin
      cls_d   = cls_q;
      shown_d = shown_q;
      if (latch) begin
         cls_d   = CYC_READ;
         shown_d = ~stb_n[I_OE];
      end else if (wr_kill) begin
         cls_d   = CYC_EARLY_WR;
         shown_d = 1'b0;
      end else if (fall[I_RAS] & stb_n[I_CAS]) begin
         cls_d   = CYC_IDLE;
         shown_d = 1'b0;
      end else if (cls_q == CYC_READ) begin
         if (fall[I_WE] & row_open & ~stb_n[I_CAS]) begin
            if (~stb_n[I_OE])  cls_d = CYC_INDET;
            else if (shown_q)  cls_d = CYC_RMW;
            else               cls_d = CYC_LATE_WR;
         end else if (~stb_n[I_OE]) begin
            shown_d = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cls_q   <= CYC_IDLE;
         shown_q <= 1'b0;
      end else begin
         cls_q   <= cls_d;
         shown_q <= shown_d;
      end
   end

   assert_indet_from_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_q == CYC_INDET && $past(cls_q) != CYC_INDET) |-> $past(cls_q) == CYC_READ);
endmodule

// File: rtl/dqb_out_stage.sv
module dqb_out_stage
   import dqb_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned EDO_MODE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSTB-1:0]   stb_n,
   input  logic [NSTB-1:0]   lvl_q,
   input  cyc_e              cls_q,
   input  logic              latch,
   input  logic              wr_kill,
   input  logic [DATA_W-1:0] cell_data,
   output logic [DATA_W-1:0] data_q,
   output logic              drv
);
   logic valid_q;
   logic strobe_off;
   logic late_cut;

   assign late_cut = (cls_q == CYC_LATE_WR) & stb_n[I_CAS];

   if (EDO_MODE == 0) begin : g_fpm
      assign strobe_off = stb_n[I_RAS] | stb_n[I_CAS];

      assert_fpm_first_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (lvl_q[I_RAS] || lvl_q[I_CAS]) |-> !valid_q);
   end else if (EDO_MODE == 1) begin : g_edo
      assign strobe_off = stb_n[I_RAS] & stb_n[I_CAS];

      assert_edo_both_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (lvl_q[I_RAS] && lvl_q[I_CAS]) |-> !valid_q);
      assert_edo_persist_R4: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(valid_q) && !(lvl_q[I_RAS] && lvl_q[I_CAS])
          && cls_q != CYC_LATE_WR && cls_q != CYC_EARLY_WR) |-> valid_q);
   end else begin : g_bad_mode
      $error("dqb_out_stage: EDO_MODE must be 0 or 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
      end else if (latch) begin
         valid_q <= 1'b1;
         data_q  <= cell_data;
      end else if (wr_kill || strobe_off || late_cut) begin
         valid_q <= 1'b0;
      end
   end

   assign drv = valid_q & ~lvl_q[I_OE];

   assert_cbr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(lvl_q[I_RAS]) && !lvl_q[I_CAS] && $past(!lvl_q[I_CAS])) |-> $stable(data_q));
endmodule

// File: rtl/dram_dq_ctrl.sv
module dram_dq_ctrl
   import dqb_pkg::*;
#(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned EDO_MODE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] cell_data,
   output logic [DATA_W-1:0] dq_q,
   output logic              dq_drv,
   output logic              dq_indet
);
   if (DATA_W < 1) begin : g_bad_width
      $error("dram_dq_ctrl: DATA_W must be at least 1");
   end

   logic [NSTB-1:0]  stb_n;
   logic [NSTB-1:0]  lvl_q;
   logic [NEDGE-1:0] fall;
   cyc_e             cls_q;
   logic             latch, wr_kill;

   always_comb begin
      stb_n        = '1;
      stb_n[I_RAS] = ras_n;
      stb_n[I_CAS] = cas_n;
      stb_n[I_WE]  = we_n;
      stb_n[I_OE]  = oe_n;
   end

   dqb_sampler #(.N_STB(NSTB), .N_EDGE(NEDGE)) u_sampler (
      .clk   (clk),
      .rst_n (rst_n),
      .stb_n (stb_n),
      .lvl_q (lvl_q),
      .fall  (fall)
   );

   dqb_classifier u_classifier (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb_n   (stb_n),
      .fall    (fall),
      .cls_q   (cls_q),
      .latch   (latch),
      .wr_kill (wr_kill)
   );

   dqb_out_stage #(.DATA_W(DATA_W), .EDO_MODE(EDO_MODE)) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .stb_n     (stb_n),
      .lvl_q     (lvl_q),
      .cls_q     (cls_q),
      .latch     (latch),
      .wr_kill   (wr_kill),
      .cell_data (cell_data),
      .data_q    (dq_q),
      .drv       (dq_drv)
   );

   assign dq_indet = (cls_q == CYC_INDET);

   assert_early_write_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_q == CYC_EARLY_WR) |-> !dq_drv);
   assert_late_cas_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cls_q == CYC_LATE_WR && lvl_q[I_CAS]) |-> !dq_drv);
endmodule

// File: tb/test_dram_dq_ctrl.sv
module test_dram_dq_ctrl;
   localparam int unsigned W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
   logic [W-1:0] cell_data = '0;
   logic [W-1:0] q_f, q_e;
   logic drv_f, drv_e, ind_f, ind_e;
   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dram_dq_ctrl #(.DATA_W(W), .EDO_MODE(0)) i_dram_dq_ctrl (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
      .cell_data(cell_data), .dq_q(q_f), .dq_drv(drv_f), .dq_indet(ind_f));

   dram_dq_ctrl #(.DATA_W(W), .EDO_MODE(1)) i_dram_dq_ctrl_edo (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n),
      .cell_data(cell_data), .dq_q(q_e), .dq_drv(drv_e), .dq_indet(ind_e));

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic r, input logic c, input logic w, input logic o, input logic [W-1:0] d);
      @(negedge clk);
      ras_n = r; cas_n = c; we_n = w; oe_n = o; cell_data = d;
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      apply(1'b1, 1'b1, 1'b1, 1'b1, '0);
   endtask

   task automatic t_reset();
      chk("R1", "fpm drv", drv_f, 0);   chk("R1", "fpm q", q_f, 0);   chk("R1", "fpm indet", ind_f, 0);
      chk("R1", "edo drv", drv_e, 0);   chk("R1", "edo q", q_e, 0);   chk("R1", "edo indet", ind_e, 0);
   endtask

   task automatic t_read();
      idle();
      apply(0, 1, 1, 1, '0);
      apply(0, 0, 1, 0, 16'hA5A5);
      chk("R2", "fpm drv", drv_f, 1); chk("R2", "fpm q", q_f, 16'hA5A5);
      chk("R2", "edo drv", drv_e, 1); chk("R2", "edo q", q_e, 16'hA5A5);
      apply(0, 0, 1, 1, 16'hA5A5);
      chk("R11", "fpm drv oe high", drv_f, 0); chk("R11", "edo drv oe high", drv_e, 0);
      apply(0, 0, 1, 0, 16'hA5A5);
      chk("R11", "fpm drv oe low", drv_f, 1); chk("R11", "edo drv oe low", drv_e, 1);
      apply(0, 1, 1, 0, 16'hA5A5);
      chk("R3", "fpm drv cas high", drv_f, 0);
      chk("R4", "edo drv cas high", drv_e, 1); chk("R4", "edo q cas high", q_e, 16'hA5A5);
      apply(0, 0, 1, 0, 16'h3C3C);
      chk("R4", "fpm page q", q_f, 16'h3C3C); chk("R4", "edo page q", q_e, 16'h3C3C);
      chk("R4", "edo page drv", drv_e, 1);
      apply(1, 0, 1, 0, 16'h3C3C);
      chk("R3", "fpm drv ras high", drv_f, 0); chk("R4", "edo drv ras high", drv_e, 1);
      apply(1, 1, 1, 0, 16'h3C3C);
      chk("R4", "edo drv both high", drv_e, 0);
      idle();
   endtask

   task automatic t_cbr_hold();
      idle();
      apply(0, 1, 1, 1, '0);
      apply(0, 0, 1, 0, 16'h1234);
      apply(1, 0, 1, 0, 16'h1234);
      chk("R5", "edo drv before ras fall", drv_e, 1);
      apply(0, 0, 1, 0, 16'hDEAD);
      chk("R5", "edo q held", q_e, 16'h1234); chk("R5", "edo drv held", drv_e, 1);
      chk("R5", "fpm q held", q_f, 16'h1234); chk("R5", "fpm drv", drv_f, 0);
      apply(1, 1, 1, 1, '0);
      idle();
   endtask

   task automatic t_early_write();
      idle();
      apply(0, 1, 1, 1, '0);
      apply(0, 0, 0, 0, 16'hBEEF);
      chk("R6", "fpm drv", drv_f, 0); chk("R6", "edo drv", drv_e, 0);
      chk("R6", "fpm q kept", q_f, 16'h1234); chk("R6", "edo q kept", q_e, 16'h1234);
      apply(0, 0, 0, 0, 16'hBEEF);
      chk("R6", "edo drv later", drv_e, 0);
      apply(0, 0, 1, 0, 16'hBEEF);
      chk("R6", "fpm drv we high", drv_f, 0); chk("R6", "edo drv we high", drv_e, 0);
      idle();
   endtask

   task automatic t_late_write();
      idle();
      apply(0, 1, 1, 1, '0);
      apply(0, 0, 1, 1, 16'h0F0F);
      apply(0, 0, 0, 1, 16'h0F0F);
      chk("R7", "fpm drv open", drv_f, 0); chk("R7", "edo drv open", drv_e, 0);
      chk("R7", "edo indet", ind_e, 0);
      apply(0, 0, 0, 0, 16'h0000);
      chk("R7", "fpm drv again", drv_f, 1); chk("R7", "fpm q old", q_f, 16'h0F0F);
      chk("R7", "edo drv again", drv_e, 1); chk("R7", "edo q old", q_e, 16'h0F0F);
      idle();
   endtask

   task automatic t_late_cas_first();
      idle();
      apply(0, 1, 1, 1, '0);
      apply(0, 0, 1, 1, 16'h7777);
      apply(0, 0, 0, 1, 16'h7777);
      apply(0, 1, 0, 1, 16'h7777);
      apply(0, 1, 0, 0, 16'h7777);
      chk("R8", "fpm drv", drv_f, 0); chk("R8", "edo drv", drv_e, 0);
      idle();
   endtask

   task automatic t_rmw();
      idle();
      apply(0, 1, 1, 1, '0);
      apply(0, 0, 1, 0, 16'h55AA);
      chk("R9", "edo drv read", drv_e, 1);
      apply(0, 0, 1, 1, 16'h55AA);
      apply(0, 0, 0, 1, 16'h55AA);
      chk("R9", "edo drv oe high", drv_e, 0); chk("R9", "edo indet", ind_e, 0);
      apply(0, 0, 0, 0, 16'h0000);
      chk("R9", "fpm drv", drv_f, 1); chk("R9", "fpm q", q_f, 16'h55AA);
      chk("R9", "edo drv", drv_e, 1); chk("R9", "edo q", q_e, 16'h55AA);
      apply(0, 1, 0, 0, 16'h0000);
      chk("R9", "edo drv cas high", drv_e, 1); chk("R9", "edo q cas high", q_e, 16'h55AA);
      chk("R9", "fpm drv cas high", drv_f, 0);
      idle();
   endtask

   task automatic t_indet();
      idle();
      apply(0, 1, 1, 1, '0);
      apply(0, 0, 1, 0, 16'hC0DE);
      chk("R10", "fpm indet before", ind_f, 0);
      apply(0, 0, 0, 0, 16'hC0DE);
      chk("R10", "fpm indet", ind_f, 1); chk("R10", "edo indet", ind_e, 1);
      idle();
      chk("R10", "edo indet kept", ind_e, 1);
      apply(0, 1, 1, 1, '0);
      chk("R10", "fpm indet cleared", ind_f, 0); chk("R10", "edo indet cleared", ind_e, 0);
      idle();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_read();
      t_cbr_hold();
      t_early_write();
      t_late_write();
      t_late_cas_first();
      t_rmw();
      t_indet();
      done = 1'b1;
   end

   initial begin
      for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected done");
      end
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule